// File: doc/BRIEF.md
# Dual interval timer unit

This block holds the two 16-bit down-counters of a parallel interface adapter. Both counters step down by one on each cycle in which the 1 MHz tick enable is high. Each counter raises an interrupt flag when it times out. The flags leave the block as two separate outputs, so that a neighbouring flag/enable register can place them in its own status byte.

Software reaches the timers through a byte-wide register window selected by a 4-bit address. A write to a timer's high byte is the start command. It loads the whole counter, arms the timer and clears that timer's flag. A read of a timer's low counter byte acknowledges, and so clears, the flag.

Timer 1 has a full 16-bit latch and a free-running mode, in which it reloads itself from the latch on every timeout. Timer 2 is always one-shot.

Each timer is driven by a small state machine with three states:
- `CH_IDLE`: after reset, never started.
- `CH_ARMED`: started, and a timeout will raise the flag.
- `CH_EXPIRED`: a one-shot timeout has already been reported.

The named transitions are:
- START: any state to `CH_ARMED`, on a high-byte write.
- EXPIRE: `CH_ARMED` to `CH_EXPIRED`, on a timeout in one-shot operation.
- RELOAD: `CH_ARMED` stays in `CH_ARMED`, on a timeout in free-running operation.

Top module: `dual_timer`

## Requirements
- R1: After reset, both counters and all latch bytes are zero, both flags are low and both timers are idle. A read of any timer register returns 0x00.
- R2: A write to a timer's low-byte select (4 for timer 1, 8 for timer 2) stores the data in that timer's low latch only. The running counter keeps its value.
- R3: A write to a timer's high-byte select (5 for timer 1, 9 for timer 2) loads the counter with {written byte, low latch}, clears that timer's flag and arms the timer. When a tick falls in the same cycle, the load takes priority over the decrement.
- R4: The counter decreases by one on each clock edge where the tick enable is high, and holds its value on every other edge.
- R5: A timeout is a tick that arrives while the counter is zero. In one-shot operation the counter then wraps to 0xFFFF. Only the first timeout after a start sets the flag. Later wraps leave the flag low.
- R6: With `t1_free_run` high, a timer 1 timeout reloads the counter from the full 16-bit latch and sets the flag on every timeout.
- R7: Timer 2 ignores `t1_free_run`. It always wraps to 0xFFFF on timeout and never reloads.
- R8: A read of the low counter byte (select 4 or 8) returns the counter's low byte and clears that timer's flag. A read of the high byte (select 5 or 9) returns the counter's high byte and changes nothing. A timeout in the same cycle as a low-byte read leaves the flag set.
- R9: Read data is combinational on `rd_en` and `reg_sel`. Selects other than 4, 5, 8 and 9, and any cycle without `rd_en`, return 0x00. `t1_flag` is meant for status bit 6 and `t2_flag` for status bit 5. Each flag changes only through its own timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 1 MHz count enable |
| reg_sel | input | 4 | Register select |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| t1_free_run | input | 1 | Timer 1 free-running mode (auxiliary control bit 6) |
| rd_data | output | 8 | Read data |
| t1_flag | output | 1 | Timer 1 timeout flag (status bit 6) |
| t2_flag | output | 1 | Timer 2 timeout flag (status bit 5) |

## Verification
The hardest case to reach from the ports is the absence of a second one-shot flag. A counter that has already expired must run through a complete 65536-tick wrap before the condition can be observed, so the stimulus holds the tick high for 65540 cycles after acknowledging the first timeout. The collision between a timeout and a low-byte read is also narrow. The stimulus counts the counter down to exactly zero and then issues the read together with the final tick in a single cycle. The priority of a load over a same-cycle tick is reached the same way, by asserting a high-byte write and the tick together.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_ARMED   = 2'd1,
        CH_EXPIRED = 2'd2
    } ch_state_t;

    localparam logic [3:0] SEL_T1_LO = 4'h4;
    localparam logic [3:0] SEL_T1_HI = 4'h5;
    localparam logic [3:0] SEL_T2_LO = 4'h8;
    localparam logic [3:0] SEL_T2_HI = 4'h9;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/dtmr_regif.sv
module dtmr_regif
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CH     = NUM_CH,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic [3:0]                  reg_sel,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [CH-1:0][CNT_W-1:0]    counts,
    output logic [CH-1:0]               ld_lo,
    output logic [CH-1:0]               ld_hi,
    output logic [CH-1:0]               rd_clr,
    output logic [DATA_W-1:0]           rd_data
);

    function automatic logic [3:0] lo_addr(input int idx);
        return (idx == 0) ? SEL_T1_LO : SEL_T2_LO;
    endfunction

    function automatic logic [3:0] hi_addr(input int idx);
        return (idx == 0) ? SEL_T1_HI : SEL_T2_HI;
    endfunction

    for (genvar g = 0; g < CH; g++) begin : g_strobe
        assign ld_lo[g]  = wr_en && (reg_sel == lo_addr(g));
        assign ld_hi[g]  = wr_en && (reg_sel == hi_addr(g));
        assign rd_clr[g] = rd_en && (reg_sel == lo_addr(g));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < CH; i++) begin
            if (rd_en && reg_sel == lo_addr(i)) begin
                rd_data = counts[i][DATA_W-1:0];
            end
            if (rd_en && reg_sel == hi_addr(i)) begin
                rd_data = counts[i][CNT_W-1:DATA_W];
            end
        end
    end

endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
    import dtmr_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter bit RELOAD_CAP = 1'b0,
    localparam int CNT_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              rd_clr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              free_run,
    output logic [CNT_W-1:0]  count,
    output logic              flag
);

    ch_state_t         state_q, state_d;
    logic [DATA_W-1:0] lo_q, hi_q;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              flag_q, flag_d;
    logic              reload_en, timeout, fire;

    assign reload_en = RELOAD_CAP && free_run;
    assign timeout   = tick && !ld_hi && (cnt_q == '0);
    assign fire      = timeout && (state_q == CH_ARMED);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: START, EXPIRE, RELOAD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (ld_hi) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (ld_hi)                       state_d = CH_ARMED;
                else if (timeout && !reload_en)  state_d = CH_EXPIRED;
            end
            CH_EXPIRED: begin
                if (ld_hi) state_d = CH_ARMED;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Datapath and flag outputs
    always_comb begin
        cnt_d = cnt_q;
        if (ld_hi) begin
            cnt_d = {wdata, lo_q};
        end else if (timeout && reload_en) begin
            cnt_d = {hi_q, lo_q};
        end else if (tick) begin
            cnt_d = cnt_q - CNT_W'(1);
        end

        flag_d = flag_q;
        if (ld_hi) begin
            flag_d = 1'b0;
        end else if (fire) begin
            flag_d = 1'b1;
        end else if (rd_clr) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ld_lo) lo_q <= wdata;
            if (ld_hi) hi_q <= wdata;
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    assign count = cnt_q;
    assign flag  = flag_q;

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hi |=> cnt_q == {$past(wdata), $past(lo_q)});  // R3
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hi |=> (!flag_q && state_q == CH_ARMED));  // R3
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_hi && cnt_q != '0) |=> cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)));  // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_hi) |=> $stable(cnt_q));  // R4
    AST_ONE_SHOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_EXPIRED && !flag_q && !ld_hi) |=> !flag_q);  // R5
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && reload_en) |=> cnt_q == {$past(hi_q), $past(lo_q)});  // R6

endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [3:0]        reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              t1_free_run,
    output logic [DATA_W-1:0] rd_data,
    output logic              t1_flag,
    output logic              t2_flag
);

    logic [NUM_CH-1:0][CNT_W-1:0] counts;
    logic [NUM_CH-1:0]            ld_lo, ld_hi, rd_clr, flags;

    dtmr_regif #(.DATA_W(DATA_W), .CH(NUM_CH)) u_regif (
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .counts  (counts),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .rd_clr  (rd_clr),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dtmr_chan #(.DATA_W(DATA_W), .RELOAD_CAP(g == 0)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .ld_lo    (ld_lo[g]),
            .ld_hi    (ld_hi[g]),
            .rd_clr   (rd_clr[g]),
            .wdata    (wr_data),
            .free_run (t1_free_run),
            .count    (counts[g]),
            .flag     (flags[g])
        );
    end

    assign t1_flag = flags[0];
    assign t2_flag = flags[1];

endmodule

// File: tb/dual_timer_test.sv
module dual_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] reg_sel = 4'h0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       t1_free_run = 1'b0;
    logic [7:0] rd_data;
    logic       t1_flag, t2_flag;

    always #2 clk = ~clk;

    dual_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .reg_sel     (reg_sel),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .wr_data     (wr_data),
        .t1_free_run (t1_free_run),
        .rd_data     (rd_data),
        .t1_flag     (t1_flag),
        .t2_flag     (t2_flag)
    );

    typedef struct {
        int    kind;   // 0 rd_data, 1 t1_flag, 2 t2_flag
        int    exp;
        string req;
    } item_t;

    item_t sb[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;

    // Monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            int    act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = int'(rd_data);
                1:       act = int'(t1_flag);
                default: act = int'(t2_flag);
            endcase
            n_checks++;
            if (act != it.exp) begin
                n_fails++;
                $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input int exp, input string req);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb.push_back(it);
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        tick  = 1'b0;
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d, input logic t = 1'b0);
        reg_sel = s;
        wr_data = d;
        wr_en   = 1'b1;
        tick    = t;
        settle();
    endtask

    task automatic rd(input logic [3:0] s, input int exp, input string req, input logic t = 1'b0);
        reg_sel = s;
        rd_en   = 1'b1;
        tick    = t;
        push(0, exp, req);
        settle();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            settle();
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();

        // R1: reset state
        push(1, 0, "R1");
        push(2, 0, "R1");
        rd(4'h4, 8'h00, "R1");
        rd(4'h9, 8'h00, "R1");

        // R2/R3: low latch then start
        wr(4'h4, 8'h10);
        rd(4'h4, 8'h00, "R2");
        wr(4'h5, 8'h00);
        rd(4'h5, 8'h00, "R3");
        rd(4'h4, 8'h10, "R3");

        // R4/R5: count down to zero, then the timeout
        ticks(16);
        push(1, 0, "R5");
        rd(4'h4, 8'h00, "R4");
        ticks(1);
        push(1, 1, "R5");
        rd(4'h5, 8'hFF, "R8");
        push(1, 1, "R8");
        rd(4'h4, 8'hFF, "R5");
        push(1, 0, "R8");

        // R5: a full wrap after expiry raises no second flag
        ticks(65540);
        push(1, 0, "R5");
        rd(4'h4, 8'hFB, "R4");

        // R2: a low write leaves the running counter alone
        wr(4'h4, 8'h33);
        rd(4'h4, 8'hFB, "R2");
        rd(4'h5, 8'hFF, "R2");
        wr(4'h5, 8'h01);
        rd(4'h4, 8'h33, "R3");
        rd(4'h5, 8'h01, "R3");

        // R3: a load beats a same-cycle tick
        wr(4'h5, 8'h00, 1'b1);
        rd(4'h4, 8'h33, "R3");

        // R8: a timeout beats a same-cycle low read
        ticks(51);
        rd(4'h4, 8'h00, "R8", 1'b1);
        push(1, 1, "R8");
        wr(4'h5, 8'h00);
        push(1, 0, "R3");

        // R6: free-running reload
        t1_free_run = 1'b1;
        wr(4'h4, 8'h03);
        wr(4'h5, 8'h00);
        ticks(4);
        push(1, 1, "R6");
        rd(4'h4, 8'h03, "R6");
        push(1, 0, "R6");
        ticks(4);
        push(1, 1, "R6");
        rd(4'h5, 8'h00, "R6");

        // R7: timer 2 stays one-shot in free-running mode
        wr(4'h8, 8'h05);
        wr(4'h9, 8'h00);
        push(2, 0, "R7");
        ticks(5);
        push(2, 0, "R7");
        ticks(1);
        push(2, 1, "R7");
        rd(4'h9, 8'hFF, "R7");
        rd(4'h8, 8'hFF, "R7");
        push(2, 0, "R8");
        push(1, 1, "R9");

        // R9: unmapped select reads zero
        rd(4'h6, 8'h00, "R9");

        repeat (3) @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule